// File: doc/BRIEF.md
# SCSI Host Adapter Command Register Engine

This block is the register file of a simplified SCSI host adapter, as seen from a processor bus. It holds two banks of byte registers sharing one index space: a write-side bank that records every byte the processor stores, and a read-side bank that holds the results the processor reads back. The bus is word-spaced, so the register index comes from address bits above the two lowest.

A byte written to the command index is decoded into an action. Depending on the action, the block loads fixed codes into the result registers (status, interrupt cause, sequence step). It can also clear the read-side bank, raise an interrupt request, and pulse a start strobe. One strobe goes to a DMA transfer engine and the other goes to a command-descriptor decoder. The result codes are chosen by the command itself, not by following a live bus phase. A select-with-attention command looks up the target identifier most recently written to the write-side bank. If that target is absent, the command reports a disconnect and does not start the descriptor decoder.

Top module: `scsi_cmd_engine`

## Requirements
- R1: The register index is `bus_addr[5:2]`. Bits 1:0 are ignored for both reads and writes. `bus_rdata` returns, combinationally, the read-side register at that index.
- R2: After reset, every read-side register is 0x00 except index 14, which holds the revision value 0x04. `irq`, `xfer_start` and `cdb_start` are low.
- R3: A write to index 3 is a command. Only bits 6:0 of the byte select the command, so bit 7 has no effect on the outcome.
- R4: Command 0x01 (flush) sets index 6 (sequence step) to 0x00 and index 5 (interrupt cause) to 0x08. It leaves index 4 (status) and `irq` unchanged.
- R5: Command 0x02 clears every read-side register and then sets index 14 to 0x04. `irq` is unchanged.
- R6: Command 0x10 (transfer information) loads status 0x93, interrupt cause 0x10 and step 0x00. It raises `irq` and pulses `xfer_start` high for the one cycle after the write edge.
- R7: Commands 0x42 and 0x43 perform select-with-attention. The target identifier is bits 2:0 of the last byte written at index 4, and the target counts as present when `tgt_present[id]` is 1. For a present target the command loads status 0x91, interrupt cause 0x18 and step 0x04, raises `irq`, and pulses `cdb_start` for one cycle.
- R8: A select-with-attention aimed at an absent target loads status 0x80, interrupt cause 0x20 and step 0x00. It raises `irq` and leaves `cdb_start` low.
- R9: Command 0x11 loads status 0x93, interrupt cause 0x18 and step 0x04. Command 0x12 loads status 0x93, interrupt cause 0x20 and step 0x00. Both raise `irq`.
- R10: Codes 0x00, 0x03, 0x1A and every code not listed above leave the read-side bank, `irq` and both strobes untouched.
- R11: A write to any index other than 3 changes no read-side register.
- R12: `irq` stays high until a cycle with `irq_ack` high. If a command that raises `irq` is written in the same cycle as the acknowledge, `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (6) | Byte address; index is bits 5:2 |
| bus_wr | input | 1 | Write enable for one cycle |
| bus_wdata | input | DATA_W (8) | Write byte |
| bus_rdata | output | DATA_W (8) | Read-side register at the addressed index |
| tgt_present | input | N_TGT (8) | One bit per target identifier, 1 if present |
| irq_ack | input | 1 | Clears the interrupt request |
| irq | output | 1 | Interrupt request |
| xfer_start | output | 1 | One-cycle start strobe to the DMA transfer engine |
| cdb_start | output | 1 | One-cycle start strobe to the command-descriptor decoder |

## Verification
A command that raises the interrupt and an acknowledge can arrive in the same clock cycle. The bench forces this by driving a transfer-information write together with `irq_ack` at one falling edge. It then expects `irq` to read high after the next rising edge, so setting wins over clearing. For contrast, the bench also pairs the acknowledge with a flush, which raises nothing, and expects `irq` to fall. The bench sweeps all 256 command bytes from a fixed baseline and compares the whole read-side bank against values it computes from the command code.

// File: rtl/scsi_eng_pkg.sv
package scsi_eng_pkg;

    // Register indices whose position the engine depends on
    localparam int unsigned IDX_CMD  = 3;
    localparam int unsigned IDX_STAT = 4;
    localparam int unsigned IDX_TGT  = 4;
    localparam int unsigned IDX_INTR = 5;
    localparam int unsigned IDX_SEQ  = 6;
    localparam int unsigned IDX_REV  = 14;
    localparam logic [7:0]  REV_VAL  = 8'h04;

    // Command codes (low 7 bits of the command byte)
    localparam logic [6:0] OP_NOP       = 7'h00;
    localparam logic [6:0] OP_FLUSH     = 7'h01;
    localparam logic [6:0] OP_CHIP_RST  = 7'h02;
    localparam logic [6:0] OP_BUS_RST   = 7'h03;
    localparam logic [6:0] OP_XFER      = 7'h10;
    localparam logic [6:0] OP_CMPL_SEQ  = 7'h11;
    localparam logic [6:0] OP_MSG_OK    = 7'h12;
    localparam logic [6:0] OP_ATN_ON    = 7'h1A;
    localparam logic [6:0] OP_SEL_ATN   = 7'h42;
    localparam logic [6:0] OP_SEL_ATN_S = 7'h43;

    // Status fields
    localparam logic [7:0] PH_DOUT   = 8'h00;
    localparam logic [7:0] PH_DIN    = 8'h01;
    localparam logic [7:0] PH_CMD    = 8'h02;
    localparam logic [7:0] PH_STS    = 8'h03;
    localparam logic [7:0] PH_MSGIN  = 8'h06;
    localparam logic [7:0] PH_MSGOUT = 8'h07;
    localparam logic [7:0] ST_TCNT   = 8'h10;
    localparam logic [7:0] ST_INT    = 8'h80;

    // Interrupt cause bits
    localparam logic [7:0] IC_DONE   = 8'h08;
    localparam logic [7:0] IC_SVC    = 8'h10;
    localparam logic [7:0] IC_DISC   = 8'h20;

    // Sequence steps
    localparam logic [7:0] STEP_IDLE = 8'h00;
    localparam logic [7:0] STEP_CDB  = 8'h04;

    typedef struct packed {
        logic       wipe;      // clear read bank, restore revision
        logic       ld_stat;
        logic       ld_intr;
        logic       ld_seq;
        logic [7:0] stat;
        logic [7:0] intr;
        logic [7:0] seq;
        logic       raise;     // request interrupt
        logic       go_xfer;   // DMA start
        logic       go_cdb;    // descriptor decoder start
    } action_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
    import scsi_eng_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [6:0] cmd_code,
    input  logic       tgt_ok,
    output action_t    act
);

    always_comb begin
        act = '0;
        if (cmd_valid) begin
            case (cmd_code)
                OP_FLUSH: begin
                    act.ld_intr = 1'b1;
                    act.intr    = IC_DONE;
                    act.ld_seq  = 1'b1;
                    act.seq     = STEP_IDLE;
                end
                OP_CHIP_RST: begin
                    act.wipe = 1'b1;
                end
                OP_XFER: begin
                    act.ld_stat = 1'b1;
                    act.ld_intr = 1'b1;
                    act.ld_seq  = 1'b1;
                    act.stat    = ST_INT | ST_TCNT | PH_STS;
                    act.intr    = IC_SVC;
                    act.seq     = STEP_IDLE;
                    act.raise   = 1'b1;
                    act.go_xfer = 1'b1;
                end
                OP_CMPL_SEQ: begin
                    act.ld_stat = 1'b1;
                    act.ld_intr = 1'b1;
                    act.ld_seq  = 1'b1;
                    act.stat    = ST_INT | ST_TCNT | PH_STS;
                    act.intr    = IC_SVC | IC_DONE;
                    act.seq     = STEP_CDB;
                    act.raise   = 1'b1;
                end
                OP_MSG_OK: begin
                    act.ld_stat = 1'b1;
                    act.ld_intr = 1'b1;
                    act.ld_seq  = 1'b1;
                    act.stat    = ST_INT | ST_TCNT | PH_STS;
                    act.intr    = IC_DISC;
                    act.seq     = STEP_IDLE;
                    act.raise   = 1'b1;
                end
                OP_SEL_ATN, OP_SEL_ATN_S: begin
                    act.ld_stat = 1'b1;
                    act.ld_intr = 1'b1;
                    act.ld_seq  = 1'b1;
                    act.raise   = 1'b1;
                    if (tgt_ok) begin
                        act.stat   = ST_INT | ST_TCNT | PH_DIN;
                        act.intr   = IC_SVC | IC_DONE;
                        act.seq    = STEP_CDB;
                        act.go_cdb = 1'b1;
                    end else begin
                        act.stat = ST_INT;
                        act.intr = IC_DISC;
                        act.seq  = STEP_IDLE;
                    end
                end
                default: begin
                    act = '0; // nop, bus reset, set attention, unknown
                end
            endcase
        end
    end

endmodule

// File: rtl/scsi_wr_bank.sv
module scsi_wr_bank #(
    parameter int unsigned NREG   = 16,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NREG-1:0][DATA_W-1:0]   bank_o
);

    logic [NREG-1:0][DATA_W-1:0] bank_d, bank_q;

    for (genvar k = 0; k < NREG; k++) begin : g_slot
        always_comb begin
            bank_d[k] = bank_q[k];
            if (wr_en && (wr_idx == IDX_W'(k))) begin
                bank_d[k] = wr_data;
            end
        end

        // R11
        wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(k)) |=> (bank_q[k] == $past(wr_data)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank_o = bank_q;

endmodule

// File: rtl/scsi_irq_ctrl.sv
module scsi_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (ack_i) irq_d = 1'b0;
        if (set_i) irq_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R12
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_q);

    // R12
    irq_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !irq_q);

    // R12
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack_i) |=> irq_q);

endmodule

// File: rtl/scsi_cmd_engine.sv
module scsi_cmd_engine
    import scsi_eng_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned N_TGT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_TGT-1:0]  tgt_present,
    input  logic              irq_ack,
    output logic              irq,
    output logic              xfer_start,
    output logic              cdb_start
);

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned NREG  = 1 << IDX_W;
    localparam int unsigned TID_W = $clog2(N_TGT);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] rbank;
        logic                        xfer;
        logic                        cdb;
    } eng_t;

    eng_t s_d, s_q;

    logic [IDX_W-1:0]            idx;
    logic                        cmd_valid;
    logic [NREG-1:0][DATA_W-1:0] wbank;
    logic [TID_W-1:0]            tgt_id;
    logic                        tgt_ok;
    action_t                     act;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign cmd_valid = bus_wr && (idx == IDX_W'(IDX_CMD));

    scsi_wr_bank #(
        .NREG   (NREG),
        .DATA_W (DATA_W)
    ) wr_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .bank_o  (wbank)
    );

    assign tgt_id = wbank[IDX_TGT][TID_W-1:0];
    assign tgt_ok = tgt_present[tgt_id];

    scsi_cmd_decode dec_i (
        .cmd_valid (cmd_valid),
        .cmd_code  (bus_wdata[6:0]),
        .tgt_ok    (tgt_ok),
        .act       (act)
    );

    scsi_irq_ctrl irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (act.raise),
        .ack_i (irq_ack),
        .irq_o (irq)
    );

    always_comb begin
        s_d      = s_q;
        s_d.xfer = act.go_xfer;
        s_d.cdb  = act.go_cdb;
        if (act.wipe) begin
            s_d.rbank          = '0;
            s_d.rbank[IDX_REV] = DATA_W'(REV_VAL);
        end
        if (act.ld_stat) s_d.rbank[IDX_STAT] = DATA_W'(act.stat);
        if (act.ld_intr) s_d.rbank[IDX_INTR] = DATA_W'(act.intr);
        if (act.ld_seq)  s_d.rbank[IDX_SEQ]  = DATA_W'(act.seq);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q                <= '0;
            s_q.rbank[IDX_REV] <= DATA_W'(REV_VAL);
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata  = s_q.rbank[idx];
    assign xfer_start = s_q.xfer;
    assign cdb_start  = s_q.cdb;

    // R11
    no_side_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx != IDX_W'(IDX_CMD)) |=> $stable(s_q.rbank));

    // R5
    chip_rst_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && bus_wdata[6:0] == OP_CHIP_RST) |=>
        (s_q.rbank[IDX_REV] == DATA_W'(REV_VAL) && s_q.rbank[IDX_STAT] == '0));

    // R6
    xfer_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && bus_wdata[6:0] == OP_XFER) |=> (xfer_start && irq));

    // R8
    absent_no_cdb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && bus_wdata[6:1] == 6'b100001 && !tgt_ok) |=> !cdb_start);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_start, cdb_start}));

    // R10
    nop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && bus_wdata[6:0] == OP_NOP && !irq_ack) |=>
        ($stable(s_q.rbank) && $stable(irq)));

endmodule

// File: tb/scsi_cmd_engine_tb.sv
module scsi_cmd_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] tgt_present = 8'hFF;
    logic       irq_ack = 1'b0;
    logic       irq, xfer_start, cdb_start;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scsi_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_present(tgt_present),
        .irq_ack(irq_ack), .irq(irq), .xfer_start(xfer_start), .cdb_start(cdb_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    // Compare every read-side index against expected status/intr/seq/rev
    task automatic bank_chk(input string req, input logic [7:0] st, input logic [7:0] ic,
                            input logic [7:0] sq, input logic [7:0] rv);
        logic [7:0] v;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] e;
            e = 8'h00;
            if (i == 4) e = st;
            if (i == 5) e = ic;
            if (i == 6) e = sq;
            if (i == 14) e = rv;
            rd(6'(i * 4), v);
            chk(req, int'(v), int'(e));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R2: reset state
        bank_chk("R2 reset bank", 8'h00, 8'h00, 8'h00, 8'h04);
        chk("R2 irq", int'(irq), 0);
        chk("R2 strobes", int'({xfer_start, cdb_start}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep all command bytes from a known baseline, target 0 present
        wr(6'h10, 8'h00);
        for (int c = 0; c < 256; c++) begin
            logic [6:0] op;
            logic [7:0] st, ic, sq, rv;
            logic ei, ex, ec;
            string req;
            op = 7'(c);
            wr(6'h0C, 8'h10); // baseline: transfer information
            ack();
            st = 8'h93; ic = 8'h10; sq = 8'h00; rv = 8'h04;
            ei = 0; ex = 0; ec = 0; req = "R10 R3 no-op";
            case (op)
                7'h01: begin ic = 8'h08; sq = 8'h00; req = "R4 R3 flush"; end
                7'h02: begin st = 0; ic = 0; sq = 0; req = "R5 R3 chip reset"; end
                7'h10: begin ei = 1; ex = 1; req = "R6 R3 xfer"; end
                7'h11: begin ic = 8'h18; sq = 8'h04; ei = 1; req = "R9 R3 cmpl"; end
                7'h12: begin ic = 8'h20; sq = 8'h00; ei = 1; req = "R9 R3 msg ok"; end
                7'h42, 7'h43: begin st = 8'h91; ic = 8'h18; sq = 8'h04; ei = 1; ec = 1;
                                    req = "R7 R3 select"; end
                default: ;
            endcase
            wr(6'h0C, 8'(c));
            chk(req, int'(xfer_start), int'(ex));
            chk(req, int'(cdb_start), int'(ec));
            chk(req, int'(irq), int'(ei));
            bank_chk(req, st, ic, sq, rv);
        end

        // R7 / R8: target presence per identifier, present set = 0..4
        tgt_present = 8'h1F;
        for (int t = 0; t < 8; t++) begin
            logic ok;
            ok = (t < 5);
            ack();
            wr(6'h10, 8'(8'hF8 | t)); // upper bits of target byte ignored
            wr(6'h0C, (t % 2 == 0) ? 8'h42 : 8'hC3);
            chk(ok ? "R7 cdb_start" : "R8 cdb_start", int'(cdb_start), int'(ok));
            chk(ok ? "R7 irq" : "R8 irq", int'(irq), 1);
            bank_chk(ok ? "R7 bank" : "R8 bank", ok ? 8'h91 : 8'h80,
                     ok ? 8'h18 : 8'h20, ok ? 8'h04 : 8'h00, 8'h04);
        end
        tgt_present = 8'hFF;

        // R11: side writes with all ones leave read bank alone
        wr(6'h0C, 8'h11);
        for (int i = 0; i < 16; i++) begin
            if (i != 3) wr(6'(i * 4 + (i % 4)), 8'hFF);
        end
        bank_chk("R11 side writes", 8'h93, 8'h18, 8'h04, 8'h04);

        // R1: low address bits ignored on read and on command write
        wr(6'h0F, 8'h12);
        for (int o = 0; o < 4; o++) begin
            rd(6'(16 + o), v); chk("R1 status alias", int'(v), 8'h93);
            rd(6'(20 + o), v); chk("R1 intr alias", int'(v), 8'h20);
        end
        wr(6'h0E, 8'h10);
        chk("R1 aliased cmd strobe", int'(xfer_start), 1);
        @(negedge clk);
        chk("R6 strobe one cycle", int'(xfer_start), 0);

        // R12: irq set and acknowledge together, set wins
        @(negedge clk);
        bus_addr = 6'h0C; bus_wr = 1'b1; bus_wdata = 8'h10; irq_ack = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; irq_ack = 1'b0;
        chk("R12 set beats ack", int'(irq), 1);
        repeat (3) @(negedge clk);
        chk("R12 irq held", int'(irq), 1);
        @(negedge clk);
        bus_addr = 6'h0C; bus_wr = 1'b1; bus_wdata = 8'h01; irq_ack = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; irq_ack = 1'b0;
        chk("R12 ack with flush clears", int'(irq), 0);

        // R5: chip reset with irq pending keeps irq
        wr(6'h0C, 8'h10);
        wr(6'h0C, 8'h82);
        chk("R5 irq unchanged", int'(irq), 1);
        bank_chk("R5 bank", 8'h00, 8'h00, 8'h00, 8'h04);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule